// File: doc/BRIEF.md
# Configuration Change Unlock Guard

This block keeps a group of protected I/O registers from being changed by a single stray store. Software must first write a fixed unlock value (0xD8) to a dedicated key address. That opens a short write window. The window is measured in retired CPU instructions, not clock cycles, so wait states and stalls do not shorten it. While the window is open, protected registers accept writes and interrupts are held off. Every retired instruction shortens the window by one. When the count reaches zero, the protected registers are locked again and interrupts are released.

The block watches the CPU's write port (address, data, strobe) and a one-cycle retire pulse. It produces one write enable per register slot. Slot `i` is at address `REG_BASE + i`, and a per-slot flag marks whether that slot is protected. It also drives an interrupt-hold line to the core and a readback byte for the key address. The remaining instruction count is exposed as a debug output.

Top module: `cfg_guard`

## Requirements
- R1: While `rst` is high at a clock edge, the count returns to 0, so `win_left`, `irq_block` and `key_rdata` all read zero.
- R2: A write of 0xD8 to `KEY_ADDR` sets `win_left` to 4 on the following clock cycle, which opens the window.
- R3: Each cycle with `insn_retire` high and a nonzero count lowers `win_left` by exactly one. The window closes when the count reaches 0. A retire pulse while the count is 0 has no effect.
- R4: A write to slot `i` whose `prot_map[i]` is 1 raises `reg_we[i]` in the same cycle only while `win_left` is nonzero. With the window closed, `reg_we[i]` stays 0 and the register keeps its value.
- R5: A write to slot `i` whose `prot_map[i]` is 0 raises `reg_we[i]` in the same cycle, whether or not the window is open.
- R6: `irq_block` is 1 exactly while `win_left` is nonzero.
- R7: `key_rdata` reads 8'h01 while the window is open and 8'h00 while it is closed. Bits 7 to 1 are always 0.
- R8: A write to `KEY_ADDR` of any value other than 0xD8 leaves `win_left` unchanged, whether the window is open or closed.
- R9: Writing 0xD8 while the window is open reloads the count to 4. A signature write and a retire pulse in the same cycle also give 4.
- R10: At most one bit of `reg_we` is high at a time, and only for an address in `REG_BASE` to `REG_BASE+NREG-1`. Writes to `KEY_ADDR` or to any other address raise no enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | CPU write strobe |
| bus_addr | input | 8 | CPU write address |
| bus_wdata | input | 8 | CPU write data |
| insn_retire | input | 1 | One-cycle pulse per retired instruction |
| prot_map | input | NREG | 1 marks slot `i` as protected |
| reg_we | output | NREG | Gated write enable for slot `i` |
| irq_block | output | 1 | Holds off interrupt service while high |
| key_rdata | output | 8 | Readback value of the key address |
| win_left | output | CNT_W | Debug: instructions left in the window |

## Verification
The bench goes after the edges of the window, where each kind of mistake shows up differently:
- **Closing edge.** It writes a protected slot on the last instruction before closing and again right after. A design that is off by one in its count either rejects the first write or accepts the second.
- **Priority and reload.** It writes the signature in the same cycle as a retire pulse, and again while the window is already open. A design that gives the retire pulse priority, or that ignores a re-unlock, ends up with a count of 3 or keeps the old count instead of 4.
- **Wrong key value.** It writes a non-signature value to the key while the window is both closed and open. A design that clears or opens the window on any key write is caught.
- **Address decode and readback.** It writes to an unprotected slot, to the key address and to an address outside the register range. A design with sloppy decode raises a stray enable, and one with a wrong readback shows a nonzero upper bit.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

    localparam int          BUS_AW     = 8;
    localparam logic [7:0]  UNLOCK_SIG = 8'hD8;
    localparam int          DEF_WINDOW = 4;

    typedef struct packed {
        logic              we;
        logic [BUS_AW-1:0] addr;
        logic [7:0]        data;
    } bus_wr_t;

    typedef enum logic [1:0] {
        WIN_HOLD,
        WIN_LOAD,
        WIN_STEP
    } win_op_e;

    function automatic logic is_unlock(input bus_wr_t w, input logic key_hit);
        return w.we && key_hit && (w.data == UNLOCK_SIG);
    endfunction

endpackage

// File: rtl/cfg_guard_decode.sv
module cfg_guard_decode
    import cfg_guard_pkg::*;
#(
    parameter int                NREG     = 8,
    parameter logic [BUS_AW-1:0] KEY_ADDR = 8'h3C,
    parameter logic [BUS_AW-1:0] REG_BASE = 8'h40
) (
    input  logic [BUS_AW-1:0] addr,
    output logic              key_hit,
    output logic [NREG-1:0]   reg_sel
);

    assign key_hit = (addr == KEY_ADDR);

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        localparam logic [BUS_AW-1:0] SLOT_ADDR = REG_BASE + BUS_AW'(i);
        assign reg_sel[i] = (addr == SLOT_ADDR);
    end

endmodule

// File: rtl/cfg_guard_window.sv
module cfg_guard_window
    import cfg_guard_pkg::*;
#(
    parameter int WINDOW = DEF_WINDOW,
    parameter int CNT_W  = $clog2(WINDOW + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    output logic [CNT_W-1:0] left,
    output logic             open
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(WINDOW);

    win_op_e op;

    always_comb begin
        if (load)                     op = WIN_LOAD;
        else if (step && left != '0)  op = WIN_STEP;
        else                          op = WIN_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else begin
            case (op)
                WIN_LOAD: left <= FULL;
                WIN_STEP: left <= left - 1'b1;
                default:  left <= left;
            endcase
        end
    end

    assign open = (left != '0);

    // R3: count never leaves its legal range
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        left <= FULL);

    // R9: signature reloads regardless of retire
    assert_reload_full_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> (left == FULL));

    // R3: retire steps down by exactly one
    assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && step && left != '0) |=> (left == $past(left) - 1'b1));

    // R8: no signature and no retire keeps the count
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(left));

endmodule

// File: rtl/cfg_guard_gate.sv
module cfg_guard_gate #(
    parameter int NREG = 8
) (
    input  logic            bus_we,
    input  logic [NREG-1:0] reg_sel,
    input  logic [NREG-1:0] prot,
    input  logic            open,
    output logic [NREG-1:0] reg_we
);

    for (genvar i = 0; i < NREG; i++) begin : g_gate
        assign reg_we[i] = bus_we && reg_sel[i] && (open || !prot[i]);
    end

endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
    import cfg_guard_pkg::*;
#(
    parameter int                NREG     = 8,
    parameter int                WINDOW   = DEF_WINDOW,
    parameter logic [BUS_AW-1:0] KEY_ADDR = 8'h3C,
    parameter logic [BUS_AW-1:0] REG_BASE = 8'h40,
    localparam int               CNT_W    = $clog2(WINDOW + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              insn_retire,
    input  logic [NREG-1:0]   prot_map,
    output logic [NREG-1:0]   reg_we,
    output logic              irq_block,
    output logic [7:0]        key_rdata,
    output logic [CNT_W-1:0]  win_left
);

    bus_wr_t         wr;
    logic            key_hit;
    logic [NREG-1:0] reg_sel;
    logic            unlock;
    logic            win_open;

    assign wr     = '{we: bus_we, addr: bus_addr, data: bus_wdata};
    assign unlock = is_unlock(wr, key_hit);

    cfg_guard_decode #(
        .NREG     (NREG),
        .KEY_ADDR (KEY_ADDR),
        .REG_BASE (REG_BASE)
    ) u_decode (
        .addr    (wr.addr),
        .key_hit (key_hit),
        .reg_sel (reg_sel)
    );

    cfg_guard_window #(
        .WINDOW (WINDOW),
        .CNT_W  (CNT_W)
    ) u_window (
        .clk  (clk),
        .rst  (rst),
        .load (unlock),
        .step (insn_retire),
        .left (win_left),
        .open (win_open)
    );

    cfg_guard_gate #(
        .NREG (NREG)
    ) u_gate (
        .bus_we  (wr.we),
        .reg_sel (reg_sel),
        .prot    (prot_map),
        .open    (win_open),
        .reg_we  (reg_we)
    );

    assign irq_block = win_open;
    assign key_rdata = {7'b0, win_open};

    // R2: the window only opens after a signature write
    assert_open_by_sig_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_block) |-> $past(bus_we && bus_addr == KEY_ADDR && bus_wdata == UNLOCK_SIG));

    // R10: never more than one slot enabled
    assert_single_we_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reg_we));

    for (genvar i = 0; i < NREG; i++) begin : g_chk
        localparam logic [BUS_AW-1:0] SLOT_ADDR = REG_BASE + BUS_AW'(i);

        // R4: protected slot locked while count is zero
        assert_locked_R4: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == SLOT_ADDR && prot_map[i] && win_left == '0) |-> !reg_we[i]);

        // R5: unprotected slot always writable
        assert_free_R5: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == SLOT_ADDR && !prot_map[i]) |-> reg_we[i]);
    end

endmodule

// File: tb/cfg_guard_test.sv
module cfg_guard_test;

    localparam int NREG  = 8;
    localparam int CNT_W = 3;

    logic            clk = 1'b0;
    logic            rst;
    logic            bus_we;
    logic [7:0]      bus_addr;
    logic [7:0]      bus_wdata;
    logic            insn_retire;
    logic [NREG-1:0] prot_map;
    logic [NREG-1:0] reg_we;
    logic            irq_block;
    logic [7:0]      key_rdata;
    logic [CNT_W-1:0] win_left;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    cfg_guard uut (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .insn_retire(insn_retire),
        .prot_map   (prot_map),
        .reg_we     (reg_we),
        .irq_block  (irq_block),
        .key_rdata  (key_rdata),
        .win_left   (win_left)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {we, addr, data, retire, exp_we (same cycle), exp_left (after edge)}
    // Key at 0x3C, slots at 0x40..0x47, slots 0..3 protected.
    localparam int NV = 16;
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 8'h40, 8'h11, 1'b0, 8'h00, 3'd0},  // R4 closed, protected
        {1'b1, 8'h44, 8'h22, 1'b0, 8'h10, 3'd0},  // R5 unprotected
        {1'b1, 8'h3C, 8'h55, 1'b0, 8'h00, 3'd0},  // R8 wrong key, closed
        {1'b1, 8'h3C, 8'hD8, 1'b0, 8'h00, 3'd4},  // R2 unlock
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 3'd3},  // R3 step
        {1'b1, 8'h41, 8'h33, 1'b1, 8'h02, 3'd2},  // R4 open, protected
        {1'b1, 8'h3C, 8'h00, 1'b0, 8'h00, 3'd2},  // R8 wrong key, open
        {1'b1, 8'h3C, 8'hD8, 1'b1, 8'h00, 3'd4},  // R9 reload beats retire
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 3'd3},  // R3
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 3'd2},  // R3
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 3'd1},  // R3
        {1'b1, 8'h43, 8'h44, 1'b0, 8'h08, 3'd1},  // R4 last open instruction
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 3'd0},  // R3 closes
        {1'b1, 8'h43, 8'h55, 1'b0, 8'h00, 3'd0},  // R4 just after close
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 3'd0},  // R3 retire when closed
        {1'b1, 8'h50, 8'h66, 1'b0, 8'h00, 3'd0}   // R10 out of range
    };

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        insn_retire = 1'b0; prot_map = 8'h0F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 win_left", 32'(win_left), 0);
        chk("R1 key_rdata", 32'(key_rdata), 0);
        chk("R6 irq_block", 32'(irq_block), 0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            logic [28:0] v;
            v = VEC[k];
            @(negedge clk);
            bus_we = v[28]; bus_addr = v[27:20]; bus_wdata = v[19:12];
            insn_retire = v[11];
            #1;
            chk("R4/R5/R10 reg_we", 32'(reg_we), 32'(v[10:3]));
            @(posedge clk);
            #1;
            chk("R2/R3/R8/R9 win_left", 32'(win_left), 32'(v[2:0]));
            chk("R6 irq_block", 32'(irq_block), 32'(v[2:0] != 0));
            chk("R7 key_rdata", 32'(key_rdata), (v[2:0] != 0) ? 32'h01 : 32'h00);
        end

        // R7 readback while open, then R1 reset mid-window
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h3C; bus_wdata = 8'hD8; insn_retire = 1'b0;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R7 key_rdata open", 32'(key_rdata), 32'h01);
        chk("R2 win_left", 32'(win_left), 4);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 win_left mid-window", 32'(win_left), 0);
        chk("R1 irq_block mid-window", 32'(irq_block), 0);
        chk("R1 key_rdata mid-window", 32'(key_rdata), 0);
        @(negedge clk);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule